// File: doc/BRIEF.md
# Triple-channel hold and conversion sequencer

This block is the digital control side of a converter that samples three input channels at the same moment. Each channel has its own active-low hold input. A falling edge on that input freezes the channel and starts a conversion of fixed length on the converter clock. When the conversion ends, the channel goes back to tracking its input. The block raises a one-clock end-of-conversion pulse and stores a result word in that channel's slot. The result is a deterministic stand-in value, not a real quantiser output.

Each hold input is synchronised and edge-detected inside the block. Once a channel has been captured, it ignores its hold input until its own conversion ends or a synchronous reset occurs. Any mix of channels can be captured on the same clock. A host reads a channel's slot through a select input. A per-channel done flag stays set from the end of the conversion until the host reads that slot. The nominal repeat period is 20 clocks: 16 clocks of conversion followed by an acquisition interval, during which the channel is idle and a fresh falling edge is accepted.

Top module: `tri_hold_conv_seq`

## Requirements
- R1: While `rst` is high at a rising edge, every busy flag, done flag, result slot and the `eoc` output clear to 0. Per-channel conversion counts restart, so the first result after reset carries count 1.
- R2: Let k be the first rising edge at which a hold input is sampled low after being high. The channel's `busy` bit reads 1 after edge k+SYNC_STAGES and 0 before it. With the default of 2, `busy` first reads high after the third edge.
- R3: `busy` stays high for exactly CONV_CYCLES clocks (16 by default). It then returns low, which puts the channel back into acquisition.
- R4: On the edge where a channel's `busy` drops, that channel's `done` bit goes to 1 and `eoc` goes high. `eoc` stays high for one clock only, unless another channel completes on the next edge.
- R5: Channels work independently. Channels captured together complete together and produce a single `eoc` pulse. Channels captured at different times complete at their own times.
- R6: Falling edges on a hold input while its channel is busy are ignored. They neither restart nor lengthen the conversion.
- R7: A hold input that stays low after capture starts no further conversion. A new high-to-low transition after the conversion has ended is accepted at once, so a 20-clock repeat period works.
- R8: `rd_data` combinationally shows the slot selected by `rd_ch`. Bits [15:14] of a result hold the channel index (A=0, B=1, C=2). Bits [13:0] hold the number of conversions that channel has completed since reset. A `rd_ch` value of NCH or more reads as 0.
- R9: A rising edge with `rd_en` high and `rd_ch` selecting a channel clears that channel's `done` and no other. An out-of-range `rd_ch` clears nothing. If a completion and a read of the same channel fall on the same edge, `done` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high; re-arms all hold inputs |
| hold_n | input | NCH | Active-low hold request per channel (bit 0 = A) |
| rd_en | input | 1 | Read strobe; clears the done flag of the selected channel |
| rd_ch | input | SEL_W | Channel index to read |
| rd_data | output | RES_W | Result slot of the selected channel |
| busy | output | NCH | Channel is in hold and converting |
| done | output | NCH | Channel has an unread result |
| eoc | output | 1 | One-clock pulse when any channel completes |

## Verification
A counter that is off by one moves the falling edge of `busy` and the `eoc` pulse by one clock, which is visible within 16 clocks of capture. A lockout or edge-detect fault shows up as a second conversion, a longer `busy` window, or a result count one higher than expected when the slot is read. A stuck or wrongly cleared done flag shows on the `done` port on the edge after the read or after the completion. A wrong slot write shows as a wrong index or count on `rd_data` as soon as that channel is selected.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
   // status bundle handed from each channel to the top
   typedef struct packed {
      logic busy;
      logic done;
      logic fin;   // completing on the coming edge
   } chan_stat_t;
endpackage

// File: rtl/tcs_hold_edge.sv
module tcs_hold_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic hold_n,
   output logic fall
);
   logic cur;
   logic prev;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign cur = hold_n;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain;
         always_ff @(posedge clk) begin
            if (rst) chain <= '1;
            else     chain <= (chain << 1) | SYNC_STAGES'(hold_n);
         end
         assign cur = chain[SYNC_STAGES-1];
      end
   endgenerate

   // preset high so that reset re-arms the edge detector
   always_ff @(posedge clk) begin
      if (rst) prev <= 1'b1;
      else     prev <= cur;
   end

   assign fall = prev & ~cur;

   // R2: an edge is reported for a single clock only
   a_r2_fall_single: assert property (@(posedge clk) disable iff (rst)
      fall |=> !fall);
endmodule

// File: rtl/tcs_channel.sv
module tcs_channel import tcs_pkg::*; #(
   parameter int CONV_CYCLES = 16,
   parameter int RES_W       = 16,
   parameter int CH_W        = 2,
   parameter int CH_IDX      = 0,
   parameter int CNT_W       = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             fall,
   input  logic             rd_clr,
   output chan_stat_t       stat,
   output logic [RES_W-1:0] result
);
   localparam int SEQ_W = RES_W - CH_W;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_CYCLES - 1);

   logic             busy;
   logic             done;
   logic [CNT_W-1:0] cnt;
   logic [SEQ_W-1:0] seq;
   logic             last;

   assign last = busy && (cnt == LAST);

   always_ff @(posedge clk) begin
      if (rst) begin
         busy   <= 1'b0;
         done   <= 1'b0;
         cnt    <= '0;
         seq    <= '0;
         result <= '0;
      end else begin
         if (busy) begin
            if (last) busy <= 1'b0;
            else      cnt  <= cnt + CNT_W'(1);
         end else if (fall) begin
            busy <= 1'b1;
            cnt  <= '0;
         end
         if (last) begin
            done   <= 1'b1;
            seq    <= seq + SEQ_W'(1);
            result <= {CH_W'(CH_IDX), seq + SEQ_W'(1)};
         end else if (rd_clr) begin
            done <= 1'b0;
         end
      end
   end

   assign stat.busy = busy;
   assign stat.done = done;
   assign stat.fin  = last;

   // R3: the cycle counter never passes the final conversion cycle
   a_r3_cnt_bound: assert property (@(posedge clk) disable iff (rst)
      busy |-> cnt <= LAST);
   // R6: while converting, edges neither restart nor stall the count
   a_r6_no_restart: assert property (@(posedge clk) disable iff (rst)
      (busy && !last) |=> (busy && cnt == $past(cnt) + CNT_W'(1)));
   // R4: completion leaves the channel idle with a pending result
   a_r4_done_after_last: assert property (@(posedge clk) disable iff (rst)
      last |=> (done && !busy));
   // R7: no conversion starts without a fresh edge
   a_r7_no_spontaneous: assert property (@(posedge clk) disable iff (rst)
      (!busy && !fall) |=> !busy);
endmodule

// File: rtl/tri_hold_conv_seq.sv
module tri_hold_conv_seq import tcs_pkg::*; #(
   parameter int NCH         = 3,
   parameter int CONV_CYCLES = 16,
   parameter int SYNC_STAGES = 2,
   parameter int RES_W       = 16,
   localparam int SEL_W      = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [NCH-1:0]   hold_n,
   input  logic             rd_en,
   input  logic [SEL_W-1:0] rd_ch,
   output logic [RES_W-1:0] rd_data,
   output logic [NCH-1:0]   busy,
   output logic [NCH-1:0]   done,
   output logic             eoc
);
   localparam int CNT_W = $clog2(CONV_CYCLES + 1);

   initial begin
      assert (NCH >= 1) else $error("NCH must be at least 1");
      assert (CONV_CYCLES >= 1) else $error("CONV_CYCLES must be at least 1");
      assert (SYNC_STAGES >= 0) else $error("SYNC_STAGES must not be negative");
      assert (RES_W > SEL_W + 1) else $error("RES_W too narrow for index and count");
   end

   chan_stat_t       stat [NCH];
   logic [RES_W-1:0] slot [NCH];
   logic [NCH-1:0]   fin;

   for (genvar g = 0; g < NCH; g++) begin : g_ch
      logic fall;
      logic rd_clr;

      assign rd_clr = rd_en && (rd_ch == SEL_W'(g));

      tcs_hold_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
         .clk(clk), .rst(rst), .hold_n(hold_n[g]), .fall(fall));

      tcs_channel #(
         .CONV_CYCLES(CONV_CYCLES), .RES_W(RES_W), .CH_W(SEL_W),
         .CH_IDX(g), .CNT_W(CNT_W)
      ) u_chan (
         .clk(clk), .rst(rst), .fall(fall), .rd_clr(rd_clr),
         .stat(stat[g]), .result(slot[g]));

      assign busy[g] = stat[g].busy;
      assign done[g] = stat[g].done;
      assign fin[g]  = stat[g].fin;

      // R4: a newly set done flag always comes with the end-of-conversion pulse
      a_r4_eoc_on_done: assert property (@(posedge clk) disable iff (rst)
         $rose(done[g]) |-> eoc);
      // R9: a read without a simultaneous completion clears the flag
      a_r9_read_clears: assert property (@(posedge clk) disable iff (rst)
         (rd_clr && !fin[g]) |=> !done[g]);
   end

   always_ff @(posedge clk) begin
      if (rst) eoc <= 1'b0;
      else     eoc <= |fin;
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NCH; i++)
         if (rd_ch == SEL_W'(i)) rd_data = slot[i];
   end
endmodule

// File: tb/tri_hold_conv_seq_bench.sv
`timescale 1ns/1ps
module tri_hold_conv_seq_bench;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [2:0]  hold_n = 3'b111;
   logic        rd_en = 1'b0;
   logic [1:0]  rd_ch = 2'd0;
   logic [15:0] rd_data;
   logic [2:0]  busy;
   logic [2:0]  done;
   logic        eoc;

   int total = 0;
   int bad   = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   tri_hold_conv_seq u_tri_hold_conv_seq (
      .clk(clk), .rst(rst), .hold_n(hold_n), .rd_en(rd_en), .rd_ch(rd_ch),
      .rd_data(rd_data), .busy(busy), .done(done), .eoc(eoc));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [15:0] res(input int ch, input int cnt);
      return {ch[1:0], cnt[13:0]};
   endfunction

   task automatic read_slot(input int ch, input logic [15:0] exp, input string req);
      rd_ch = ch[1:0];
      rd_en = 1'b1;
      #1 chk(req, rd_data, exp);
      step(1);
      rd_en = 1'b0;
   endtask

   task automatic t_reset;
      rst = 1'b1; hold_n = 3'b111;
      step(3);
      rst = 1'b0;
      step(1);
      chk("R1 busy after reset", busy, 0);
      chk("R1 done after reset", done, 0);
      chk("R1 eoc after reset", eoc, 0);
      rd_ch = 2'd0; #1 chk("R1 slot zero", rd_data, 0);
   endtask

   task automatic t_single;
      hold_n[0] = 1'b0;
      step(2); chk("R2 busy not yet", busy, 3'b000);
      step(1); chk("R2 busy rises", busy, 3'b001);
      step(15); chk("R3 still converting", busy, 3'b001);
      step(1);
      chk("R3 busy drops", busy, 3'b000);
      chk("R4 eoc high", eoc, 1);
      chk("R4 done set", done, 3'b001);
      step(1); chk("R4 eoc single", eoc, 0);
      step(5); chk("R7 held low no restart", busy, 3'b000);
      read_slot(0, res(0, 1), "R8 first result A");
      chk("R9 done cleared", done, 3'b000);
      hold_n[0] = 1'b1;
      step(6);
   endtask

   task automatic t_all;
      hold_n = 3'b000;
      step(3); chk("R5 all busy", busy, 3'b111);
      step(16);
      chk("R5 all done", done, 3'b111);
      chk("R5 one eoc", eoc, 1);
      step(1); chk("R5 eoc ends", eoc, 0);
      read_slot(1, res(1, 1), "R8 result B");
      chk("R9 only B cleared", done, 3'b101);
      read_slot(2, res(2, 1), "R8 result C");
      read_slot(3, 16'h0, "R8 out of range reads 0");
      chk("R9 out of range clears nothing", done, 3'b001);
      read_slot(0, res(0, 2), "R8 second result A");
      hold_n = 3'b111;
      step(6);
   endtask

   task automatic t_lockout;
      hold_n[1] = 1'b0;
      step(5); hold_n[1] = 1'b1;
      step(4); hold_n[1] = 1'b0;
      step(9); chk("R6 not shortened", busy, 3'b010);
      step(1);
      chk("R6 ends on time", busy, 3'b000);
      chk("R6 eoc on time", eoc, 1);
      step(5); chk("R6 ignored edge started nothing", busy, 3'b000);
      read_slot(1, res(1, 2), "R6 one conversion counted");
      hold_n[1] = 1'b1;
      step(6);
   endtask

   task automatic t_cadence;
      hold_n[2] = 1'b0;
      step(10); hold_n[2] = 1'b1;
      step(9); chk("R7 first completes", eoc, 1);
      step(1); hold_n[2] = 1'b0;
      step(3); chk("R7 fresh edge accepted", busy, 3'b100);
      step(15);
      rd_ch = 2'd2; rd_en = 1'b1;
      #1 chk("R8 old value before completion", rd_data, res(2, 2));
      step(1); rd_en = 1'b0;
      chk("R9 completion wins over read", done, 3'b100);
      chk("R7 second eoc", eoc, 1);
      #1 chk("R8 new value", rd_data, res(2, 3));
      read_slot(2, res(2, 3), "R9 read to clear");
      chk("R9 cleared after read", done, 3'b000);
      hold_n[2] = 1'b1;
      step(6);
   endtask

   task automatic t_stagger;
      hold_n[0] = 1'b0;
      step(5); hold_n[2] = 1'b0;
      step(14);
      chk("R5 A completes alone", done, 3'b001);
      chk("R5 C still busy", busy, 3'b100);
      step(5);
      chk("R5 C completes later", done, 3'b101);
      chk("R5 C eoc", eoc, 1);
      read_slot(0, res(0, 3), "R8 A third");
      read_slot(2, res(2, 4), "R8 C fourth");
      hold_n = 3'b111;
      step(6);
   endtask

   task automatic t_midreset;
      hold_n[0] = 1'b0;
      step(8);
      rst = 1'b1; hold_n[0] = 1'b1;
      step(1); rst = 1'b0;
      chk("R1 busy cleared mid conversion", busy, 0);
      step(20);
      chk("R1 no late eoc", eoc, 0);
      chk("R1 no done", done, 0);
      rd_ch = 2'd0; #1 chk("R1 slot cleared", rd_data, 0);
      hold_n[0] = 1'b0;
      step(19);
      chk("R1 eoc after reset", eoc, 1);
      read_slot(0, res(0, 1), "R1 count restarts");
      hold_n[0] = 1'b1;
      step(4);
   endtask

   initial begin
      t_reset();
      t_single();
      t_all();
      t_lockout();
      t_cadence();
      t_stagger();
      t_midreset();
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog act=%h exp=%h", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule